// File: doc/BRIEF.md
# Supply Window Monitor with Filters

This block decides whether a board's input supply lies inside its allowed voltage window. It receives two digital comparator results: one that reports the supply below the low limit and one that reports it above the high limit. From these it drives a supply-good flag, a gate-enable permission for the external pass transistor, and one hysteresis-enable control per comparator.

Both comparator results first pass through a multi-flop synchronizer. Each then goes through its own glitch filter. The filter has its own length per direction, and it delays only the edge that enters the fault. A fault that clears is seen on the next cycle. The gate is not allowed to turn on for the first time until the supply has stayed in the window, without a break, for a power-on delay. After that first enable, the permission follows the window directly. All times are given as clock-cycle counts in parameters, so that simulation can use short values.

Top module: `swm_supply_window`

## Requirements
- R1: An undervoltage fault asserts only after the synchronized undervoltage comparator (`uv_below_i` = 1 means below threshold) has been high for UV_FILT_CYCLES consecutive clock edges. A shorter run has no effect on any output.
- R2: An overvoltage fault asserts only after the synchronized overvoltage comparator (`ov_above_i` = 1 means above threshold) has been high for OV_FILT_CYCLES consecutive clock edges. A shorter run has no effect on any output.
- R3: Recovery is not filtered. A fault clears on the edge after its synchronized comparator goes low, which is three edges after the input goes low.
- R4: `gate_allow_o` first asserts only after the supply has been inside the window (both faults clear) for POR_CYCLES consecutive edges, plus one output register. Leaving the window before that point restarts the count from zero.
- R5: `gate_allow_o` drops one edge after either fault asserts. Once the first power-on delay has completed, it returns one edge after the supply re-enters the window, with no new delay.
- R6: `supply_good_o` is high exactly when both faults were clear on the previous edge, and it is low while reset is applied.
- R7: With the default HYST_SRC, each hysteresis enable follows its own comparator input after the synchronizer (SYNC_STAGES edges, 2 by default). It is high while that comparator reports the tripped side.
- R8: A synchronous reset (`rst` = 1) clears `supply_good_o` and `gate_allow_o`, restarts the power-on count, and treats both directions as faulted. After reset is released with both inputs low, `supply_good_o` rises on the fourth edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uv_below_i | input | 1 | Undervoltage comparator: 1 = supply below low threshold |
| ov_above_i | input | 1 | Overvoltage comparator: 1 = supply above high threshold |
| supply_good_o | output | 1 | Supply is inside the window and the block is out of reset |
| gate_allow_o | output | 1 | Permission to enable the pass transistor gate |
| uv_hyst_en_o | output | 1 | Turns on hysteresis for the undervoltage comparator |
| ov_hyst_en_o | output | 1 | Turns on hysteresis for the overvoltage comparator |

## Verification
The bench drives comparator pulses one cycle shorter than each filter length and pulses of exactly the filter length. A filter that counts one edge too many or too few either passes a glitch or misses a real fault. It interrupts the window partway through the power-on delay: a timer that does not restart would grant the gate early. It then faults and recovers after the first enable: a design that re-runs the delay, or that filters the recovery edge, would hold the gate low for too long. Reset is applied with clean inputs to show that it withdraws both the permission and supply-good, and that it restarts the whole delay.

// File: rtl/swm_pkg.sv
package swm_pkg;

   typedef enum logic {
      HYST_FROM_COMPARATOR = 1'b0,
      HYST_FROM_FAULT      = 1'b1
   } hyst_src_e;

   localparam int DIR_UV   = 0;
   localparam int DIR_OV   = 1;
   localparam int NUM_DIRS = 2;

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
   parameter int               WIDTH     = 2,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("swm_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("swm_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stage_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RESET_VAL;
            else     stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RESET_VAL;
            else     stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/swm_fault_filter.sv
module swm_fault_filter
   import swm_pkg::*;
#(
   parameter int FILT_CYCLES = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic level_i,
   output logic fault_o
);

   if (FILT_CYCLES < 1) begin : g_bad_filt
      $error("swm_fault_filter: FILT_CYCLES must be at least 1");
   end

   localparam int            CW   = cnt_width(FILT_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

   logic [CW-1:0] run_q;
   logic          fault_q;

   // Only the edge into the fault is qualified; leaving it is immediate.
   always_ff @(posedge clk) begin
      if (rst) begin
         run_q   <= '0;
         fault_q <= 1'b1;
      end else if (!level_i) begin
         run_q   <= '0;
         fault_q <= 1'b0;
      end else if (!fault_q) begin
         if (run_q == LAST) fault_q <= 1'b1;
         else               run_q   <= run_q + 1'b1;
      end
   end

   assign fault_o = fault_q;

endmodule

// File: rtl/swm_por_timer.sv
module swm_por_timer
   import swm_pkg::*;
#(
   parameter int POR_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst,
   input  logic in_window_i,
   output logic done_o
);

   if (POR_CYCLES < 1) begin : g_bad_por
      $error("swm_por_timer: POR_CYCLES must be at least 1");
   end

   localparam int            CW   = cnt_width(POR_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          done_q;

   // Sticky once the first qualification completes; only reset clears it.
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (!in_window_i)       cnt_q  <= '0;
         else if (cnt_q == LAST) done_q <= 1'b1;
         else                    cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign done_o = done_q;

endmodule

// File: rtl/swm_supply_window.sv
module swm_supply_window
   import swm_pkg::*;
#(
   parameter int        UV_FILT_CYCLES = 120000,
   parameter int        OV_FILT_CYCLES = 1000,
   parameter int        POR_CYCLES     = 30000000,
   parameter int        SYNC_STAGES    = 2,
   parameter hyst_src_e HYST_SRC       = HYST_FROM_COMPARATOR
) (
   input  logic clk,
   input  logic rst,
   input  logic uv_below_i,
   input  logic ov_above_i,
   output logic supply_good_o,
   output logic gate_allow_o,
   output logic uv_hyst_en_o,
   output logic ov_hyst_en_o
);

   logic [NUM_DIRS-1:0] raw_vec;
   logic [NUM_DIRS-1:0] sync_vec;
   logic [NUM_DIRS-1:0] fault_vec;
   logic [NUM_DIRS-1:0] hyst_vec;
   logic                uv_sync, ov_sync;
   logic                uv_fault, ov_fault;
   logic                in_window;
   logic                por_done;
   logic                sg_q, gate_q;

   assign raw_vec[DIR_UV] = uv_below_i;
   assign raw_vec[DIR_OV] = ov_above_i;

   swm_sync #(
      .WIDTH    (NUM_DIRS),
      .STAGES   (SYNC_STAGES),
      .RESET_VAL({NUM_DIRS{1'b1}})
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (raw_vec),
      .q_o (sync_vec)
   );

   for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
      localparam int FC = (d == DIR_UV) ? UV_FILT_CYCLES : OV_FILT_CYCLES;
      swm_fault_filter #(
         .FILT_CYCLES(FC)
      ) u_filt (
         .clk     (clk),
         .rst     (rst),
         .level_i (sync_vec[d]),
         .fault_o (fault_vec[d])
      );
   end

   assign uv_sync  = sync_vec[DIR_UV];
   assign ov_sync  = sync_vec[DIR_OV];
   assign uv_fault = fault_vec[DIR_UV];
   assign ov_fault = fault_vec[DIR_OV];
   assign in_window = ~|fault_vec;

   swm_por_timer #(
      .POR_CYCLES(POR_CYCLES)
   ) u_por (
      .clk         (clk),
      .rst         (rst),
      .in_window_i (in_window),
      .done_o      (por_done)
   );

   if (HYST_SRC == HYST_FROM_COMPARATOR) begin : g_hyst_cmp
      assign hyst_vec = sync_vec;
   end else begin : g_hyst_flt
      assign hyst_vec = fault_vec;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sg_q   <= 1'b0;
         gate_q <= 1'b0;
      end else begin
         sg_q   <= in_window;
         gate_q <= in_window & por_done;
      end
   end

   assign supply_good_o = sg_q;
   assign gate_allow_o  = gate_q;
   assign uv_hyst_en_o  = hyst_vec[DIR_UV];
   assign ov_hyst_en_o  = hyst_vec[DIR_OV];

endmodule

// File: rtl/swm_checker.sv
module swm_checker
   import swm_pkg::*;
#(
   parameter int UV_FILT_CYCLES = 120000,
   parameter int OV_FILT_CYCLES = 1000,
   parameter int POR_CYCLES     = 30000000
) (
   input logic clk,
   input logic rst,
   input logic uv_sync,
   input logic ov_sync,
   input logic uv_fault,
   input logic ov_fault,
   input logic supply_good,
   input logic gate_allow
);

   localparam int UW = cnt_width(UV_FILT_CYCLES + 1);
   localparam int OW = cnt_width(OV_FILT_CYCLES + 1);
   localparam int PW = cnt_width(POR_CYCLES + 1);

   logic [UW-1:0] uv_run;
   logic [OW-1:0] ov_run;
   logic [PW-1:0] sg_run;
   logic          por_seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         uv_run   <= '0;
         ov_run   <= '0;
         sg_run   <= '0;
         por_seen <= 1'b0;
      end else begin
         if (!uv_sync) uv_run <= '0;
         else if (uv_run < UW'(UV_FILT_CYCLES)) uv_run <= uv_run + 1'b1;
         if (!ov_sync) ov_run <= '0;
         else if (ov_run < OW'(OV_FILT_CYCLES)) ov_run <= ov_run + 1'b1;
         if (!supply_good) sg_run <= '0;
         else if (sg_run < PW'(POR_CYCLES)) sg_run <= sg_run + 1'b1;
         if (supply_good && (sg_run >= PW'(POR_CYCLES - 1))) por_seen <= 1'b1;
      end
   end

   a_r1_uv_filter: assert property (@(posedge clk) disable iff (rst)
      $rose(uv_fault) |-> (uv_run >= UW'(UV_FILT_CYCLES)));

   a_r2_ov_filter: assert property (@(posedge clk) disable iff (rst)
      $rose(ov_fault) |-> (ov_run >= OW'(OV_FILT_CYCLES)));

   a_r3_uv_recover: assert property (@(posedge clk) disable iff (rst)
      !uv_sync |=> !uv_fault);

   a_r3_ov_recover: assert property (@(posedge clk) disable iff (rst)
      !ov_sync |=> !ov_fault);

   a_r4_por_before_gate: assert property (@(posedge clk) disable iff (rst)
      gate_allow |-> por_seen);

   a_r5_gate_drop: assert property (@(posedge clk) disable iff (rst)
      (uv_fault || ov_fault) |=> !gate_allow);

   a_r5_gate_in_window: assert property (@(posedge clk) disable iff (rst)
      gate_allow |-> supply_good);

   a_r6_sg_drop: assert property (@(posedge clk) disable iff (rst)
      (uv_fault || ov_fault) |=> !supply_good);

   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (!supply_good && !gate_allow));

endmodule

bind swm_supply_window swm_checker #(
   .UV_FILT_CYCLES(UV_FILT_CYCLES),
   .OV_FILT_CYCLES(OV_FILT_CYCLES),
   .POR_CYCLES    (POR_CYCLES)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .uv_sync     (uv_sync),
   .ov_sync     (ov_sync),
   .uv_fault    (uv_fault),
   .ov_fault    (ov_fault),
   .supply_good (supply_good_o),
   .gate_allow  (gate_allow_o)
);

// File: tb/tb_swm_supply_window.sv
`timescale 1ns/1ps
module tb_swm_supply_window;

   localparam int UVF = 12;
   localparam int OVF = 3;
   localparam int POR = 40;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic uv  = 1'b1;
   logic ov  = 1'b1;
   logic sg, gate, uvh, ovh;

   always #2.5 clk = ~clk;

   swm_supply_window #(
      .UV_FILT_CYCLES(UVF),
      .OV_FILT_CYCLES(OVF),
      .POR_CYCLES    (POR)
   ) dut (
      .clk           (clk),
      .rst           (rst),
      .uv_below_i    (uv),
      .ov_above_i    (ov),
      .supply_good_o (sg),
      .gate_allow_o  (gate),
      .uv_hyst_en_o  (uvh),
      .ov_hyst_en_o  (ovh)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 0;
   logic [3:0] exp_q[$];
   string      tag_q[$];

   // Requirement-level reference state
   logic m_s1u, m_s2u, m_s1o, m_s2o;
   logic m_uvf, m_ovf, m_sg, m_gate, m_por;
   int   m_runu, m_runo, m_pcnt;

   task automatic step(input logic r, input logic u, input logic o, input string tag);
      logic inwin;
      @(negedge clk);
      rst = r; uv = u; ov = o;
      if (r) begin
         m_s1u = 1; m_s2u = 1; m_s1o = 1; m_s2o = 1;
         m_uvf = 1; m_ovf = 1; m_sg = 0; m_gate = 0; m_por = 0;
         m_runu = UVF; m_runo = OVF; m_pcnt = 0;
      end else begin
         inwin = !m_uvf && !m_ovf;
         m_sg   = inwin;
         m_gate = inwin && m_por;
         if (!m_por) begin
            if (!inwin) m_pcnt = 0;
            else if (m_pcnt == POR - 1) m_por = 1;
            else m_pcnt++;
         end
         if (m_s2u) begin if (m_runu < UVF) m_runu++; end else m_runu = 0;
         if (m_s2o) begin if (m_runo < OVF) m_runo++; end else m_runo = 0;
         m_uvf = m_s2u && (m_runu >= UVF);
         m_ovf = m_s2o && (m_runo >= OVF);
         m_s2u = m_s1u; m_s1u = u;
         m_s2o = m_s1o; m_s1o = o;
      end
      exp_q.push_back({m_sg, m_gate, m_s2u, m_s2o});
      tag_q.push_back(tag);
   endtask

   task automatic run(input int n, input logic u, input logic o, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, u, o, tag);
   endtask

   // Monitor: compares each post-edge result against the scoreboard
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [3:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_checks++;
         if (sg !== e[3]) begin
            n_fail++;
            $display("FAIL %s R6 supply_good actual=%b expected=%b", t, sg, e[3]);
         end
         if (gate !== e[2]) begin
            n_fail++;
            $display("FAIL %s R4/R5 gate_allow actual=%b expected=%b", t, gate, e[2]);
         end
         if (uvh !== e[1]) begin
            n_fail++;
            $display("FAIL %s R7 uv_hyst_en actual=%b expected=%b", t, uvh, e[1]);
         end
         if (ovh !== e[0]) begin
            n_fail++;
            $display("FAIL %s R7 ov_hyst_en actual=%b expected=%b", t, ovh, e[0]);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R8: reset state, faults assumed, outputs low
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R8_reset");
      // R4 R6: clean window, power-on delay completes
      run(POR + 10, 1'b0, 1'b0, "R4_first_por");
      // R1: undervoltage pulse one short of the filter, then exactly the filter
      run(UVF - 1, 1'b1, 1'b0, "R1_uv_short");
      run(8, 1'b0, 1'b0, "R1_uv_short_after");
      run(UVF, 1'b1, 1'b0, "R1_uv_exact");
      // R3 R5: immediate recovery, gate back without new delay
      run(10, 1'b0, 1'b0, "R3_R5_uv_recover");
      // R2: overvoltage pulse one short, then exact, then long
      run(OVF - 1, 1'b0, 1'b1, "R2_ov_short");
      run(6, 1'b0, 1'b0, "R2_ov_short_after");
      run(OVF, 1'b0, 1'b1, "R2_ov_exact");
      run(6, 1'b0, 1'b0, "R3_ov_recover");
      run(8, 1'b0, 1'b1, "R2_ov_long");
      run(6, 1'b0, 1'b0, "R5_ov_regain");
      // Both comparators tripped together
      run(UVF + 2, 1'b1, 1'b1, "R1_R2_both");
      run(6, 1'b0, 1'b0, "R3_both_recover");
      // R8: reset with clean inputs restarts the delay
      for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0, "R8_reset_clean");
      // R4: window broken before the delay ends restarts the count
      run(POR / 2, 1'b0, 1'b0, "R4_partial");
      run(UVF + 3, 1'b1, 1'b0, "R4_break");
      run(POR + 8, 1'b0, 1'b0, "R4_restart");
      run(3, 1'b0, 1'b0, "R6_tail");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule